// File: doc/BRIEF.md
# Wake-up frame pattern filter

The block watches the bytes of a received Ethernet frame, one byte per accepted cycle, framed by start-of-frame and end-of-frame strobes. Starting from a programmed byte offset, it looks at a window of up to 128 frame bytes. A 128-bit byte mask picks which of those bytes count. Only the picked bytes feed a CRC-16. At the end of the frame, the bit-reversed CRC is compared with a programmed expected value. A hit produces a single-cycle match pulse.

The match can also be made to depend on the destination address. One option asks for an all-ones (broadcast) address and the other asks for a group (multicast) address. Two uses follow from this. A two-byte mask at offset 12 over the EtherType gives an "any broadcast ARP" wake filter. An empty mask with the multicast option gives an "any multicast frame" filter.

A simple write port programs three things: the configuration word, the expected CRC and the eight mask words.

Top module: `wake_pattern_filter`

## Requirements
- R1: After reset, `match_o` is low and every programmed register reads as zero, so the filter starts disabled and no frame matches until it is programmed.
- R2: Writes go to `cfg_addr`. Address 0 is the configuration word: bit 15 enable, bit 9 multicast-required, bit 8 broadcast-required, bits 7:0 start offset. Address 1 holds the expected CRC. Addresses 9 down to 2 hold mask words for window bytes 0-15, 16-31, and so on up to 112-127. Bit b of a mask word selects byte b of its 16-byte group.
- R3: The frame byte at position offset+i, with i from 0 to 127 and the first byte of the frame at position 0, goes into the CRC only when mask bit i is set. Bytes outside the window never go into the CRC.
- R4: The CRC starts at 0xFFFF for each frame. It uses the reflected polynomial 0xA001 and takes each byte LSB first. Its bit-reversed final value must equal the expected CRC.
- R5: When a frame matches, `match_o` is high for exactly the one cycle that follows the cycle in which the end-of-frame byte is accepted. It is low during the frame and after that cycle.
- R6: While the enable bit is clear, `match_o` never rises.
- R7: With broadcast-required set, a frame matches only if its first six bytes are all 0xFF.
- R8: With multicast-required set, a frame matches only if bit 0 of its first byte is 1.
- R9: A frame whose last byte comes before the highest selected window position does not match.
- R10: An all-zero mask with neither destination option set never matches.
- R11: Cycles with `rx_valid` low are ignored, whatever the other receive inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| match_o | output | 1 | One-cycle wake match pulse |

## Verification
The only result is the match pulse, and it is due in the cycle right after the clock edge that accepts the end-of-frame byte. That is one register past the edge, because the CRC and destination checks fold that last byte in combinationally. The bench drives on falling edges. It samples `match_o` at the falling edge after the end-of-frame edge to catch the pulse, and again one cycle later to confirm the pulse has ended. It also samples before every byte is driven, to confirm nothing fires while the frame is in progress. A register write takes effect on the edge that accepts it, so each frame is sent only after programming has finished.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
    localparam int WORD_W      = 16;
    localparam int MASK_WORDS  = 8;
    localparam int WIN_BYTES   = WORD_W * MASK_WORDS;
    localparam int WIN_IDX_W   = $clog2(WIN_BYTES);
    localparam int OFF_W       = 8;
    localparam int POS_W       = 11;
    localparam int ADDR_W      = 4;
    localparam int DA_BYTES    = 6;
    localparam int ADDR_CFG    = 0;
    localparam int ADDR_CRC    = 1;
    localparam int ADDR_MASK   = 2;
    localparam logic [15:0] CRC_POLY = 16'hA001;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    typedef struct packed {
        logic             en;
        logic             mc_req;
        logic             bc_req;
        logic [OFF_W-1:0] offset;
    } cfg_t;

    function automatic logic [15:0] bitrev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction
endpackage

// File: rtl/wpf_crc_step.sv
module wpf_crc_step #(
    parameter logic [15:0] POLY = 16'hA001
) (
    input  logic [15:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    logic [15:0] stage [0:8];

    assign stage[0] = crc_i ^ {8'h00, byte_i};

    for (genvar k = 0; k < 8; k++) begin : g_bit
        assign stage[k+1] = stage[k][0] ? ((stage[k] >> 1) ^ POLY) : (stage[k] >> 1);
    end

    assign crc_o = stage[8];
endmodule

// File: rtl/wpf_cfg_regs.sv
module wpf_cfg_regs
    import wpf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    output cfg_t                 cfg,
    output logic [15:0]          crc_exp,
    output logic [WIN_BYTES-1:0] mask,
    output logic                 mask_any,
    output logic [WIN_IDX_W-1:0] last_idx
);
    typedef struct packed {
        cfg_t                 cfg;
        logic [15:0]          exp;
        logic [WIN_BYTES-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (int'(addr) == ADDR_CFG) begin
                r_d.cfg.en     = wdata[15];
                r_d.cfg.mc_req = wdata[9];
                r_d.cfg.bc_req = wdata[8];
                r_d.cfg.offset = wdata[OFF_W-1:0];
            end
            if (int'(addr) == ADDR_CRC) r_d.exp = wdata;
            for (int g = 0; g < MASK_WORDS; g++) begin
                if (int'(addr) == ADDR_MASK + MASK_WORDS - 1 - g)
                    r_d.mask[g*WORD_W +: WORD_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        last_idx = '0;
        for (int i = 0; i < WIN_BYTES; i++)
            if (r_q.mask[i]) last_idx = WIN_IDX_W'(i);
    end

    assign cfg      = r_q.cfg;
    assign crc_exp  = r_q.exp;
    assign mask     = r_q.mask;
    assign mask_any = |r_q.mask;
endmodule

// File: rtl/wpf_dest_qual.sv
module wpf_dest_qual
    import wpf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat,
    input  logic       sof,
    input  logic [7:0] data,
    output logic       bc_nx,
    output logic       mc_nx,
    output logic       bc_seen,
    output logic       mc_seen
);
    localparam int CNT_W = $clog2(DA_BYTES + 1);

    typedef struct packed {
        logic             bc;
        logic             mc;
        logic [CNT_W-1:0] cnt;
    } dq_t;

    dq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (beat) begin
            if (sof) begin
                s_d.bc  = (data == 8'hFF);
                s_d.mc  = data[0];
                s_d.cnt = CNT_W'(1);
            end else if (int'(s_q.cnt) < DA_BYTES) begin
                s_d.bc  = s_q.bc && (data == 8'hFF);
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bc_nx   = s_d.bc && (int'(s_d.cnt) == DA_BYTES);
    assign mc_nx   = s_d.mc;
    assign bc_seen = s_q.bc && (int'(s_q.cnt) == DA_BYTES);
    assign mc_seen = s_q.mc;
endmodule

// File: rtl/wake_pattern_filter.sv
module wake_pattern_filter
    import wpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    output logic              match_o
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [15:0]      crc;
        logic             in_frame;
        logic             match;
    } st_t;

    st_t s_d, s_q;

    cfg_t                 cfg;
    logic [15:0]          crc_exp;
    logic [WIN_BYTES-1:0] mask;
    logic                 mask_any;
    logic [WIN_IDX_W-1:0] last_idx;
    logic                 bc_nx, mc_nx, bc_seen, mc_seen;
    logic                 cfg_en, cfg_bc_req, cfg_mc_req;

    logic [POS_W-1:0] pos_nx, win, need_pos;
    logic             in_win, sel, complete, qual, hit;
    logic [15:0]      crc_base, crc_upd, crc_nx;

    wpf_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .cfg(cfg), .crc_exp(crc_exp), .mask(mask), .mask_any(mask_any), .last_idx(last_idx)
    );

    wpf_dest_qual u_dest (
        .clk(clk), .rst_n(rst_n), .beat(rx_valid), .sof(rx_sof), .data(rx_data),
        .bc_nx(bc_nx), .mc_nx(mc_nx), .bc_seen(bc_seen), .mc_seen(mc_seen)
    );

    wpf_crc_step #(.POLY(CRC_POLY)) u_crc (
        .crc_i(crc_base), .byte_i(rx_data), .crc_o(crc_upd)
    );

    assign cfg_en     = cfg.en;
    assign cfg_bc_req = cfg.bc_req;
    assign cfg_mc_req = cfg.mc_req;

    always_comb begin
        pos_nx   = rx_sof ? '0 : ((s_q.pos == '1) ? s_q.pos : s_q.pos + 1'b1);
        win      = pos_nx - POS_W'(cfg.offset);
        in_win   = (pos_nx >= POS_W'(cfg.offset)) && (win < POS_W'(WIN_BYTES));
        sel      = in_win && mask[win[WIN_IDX_W-1:0]];
        crc_base = rx_sof ? CRC_INIT : s_q.crc;
        crc_nx   = sel ? crc_upd : crc_base;
        need_pos = POS_W'(cfg.offset) + POS_W'(last_idx);
        complete = !mask_any || (pos_nx >= need_pos);
        qual     = (!cfg.bc_req || bc_nx) && (!cfg.mc_req || mc_nx);
        hit      = cfg.en && (rx_sof || s_q.in_frame) && complete && qual
                   && (bitrev16(crc_nx) == crc_exp)
                   && (mask_any || cfg.bc_req || cfg.mc_req);

        s_d       = s_q;
        s_d.match = 1'b0;
        if (rx_valid) begin
            s_d.pos      = pos_nx;
            s_d.crc      = crc_nx;
            s_d.in_frame = rx_eof ? 1'b0 : (rx_sof ? 1'b1 : s_q.in_frame);
            s_d.match    = rx_eof && hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{pos: '0, crc: CRC_INIT, in_frame: 1'b0, match: 1'b0};
        else        s_q <= s_d;
    end

    assign match_o = s_q.match;
endmodule

// File: rtl/wpf_checker.sv
module wpf_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_eof,
    input logic match,
    input logic en,
    input logic bc_req,
    input logic mc_req,
    input logic bc_seen,
    input logic mc_seen,
    input logic mask_any
);
    AST_MATCH_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> $past(rx_valid && rx_eof)); // R5
    AST_NO_MATCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> $past(en)); // R6
    AST_BCAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (match && $past(bc_req)) |-> bc_seen); // R7
    AST_MCAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (match && $past(mc_req)) |-> mc_seen); // R8
    AST_EMPTY_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> $past(mask_any || bc_req || mc_req)); // R10
endmodule

bind wake_pattern_filter wpf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof), .match(match_o),
    .en(cfg_en), .bc_req(cfg_bc_req), .mc_req(cfg_mc_req),
    .bc_seen(bc_seen), .mc_seen(mc_seen), .mask_any(mask_any)
);

// File: tb/wake_pattern_filter_bench.sv
`timescale 1ns/1ps
module wake_pattern_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        match_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [7:0]   fr [0:255];
    logic         m_en, m_bc, m_mc;
    logic [7:0]   m_off;
    logic [15:0]  m_exp;
    logic [127:0] m_mask;

    always #2.5 clk = ~clk;

    wake_pattern_filter u_wake_pattern_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data), .match_o(match_o)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
        c = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        return c;
    endfunction

    function automatic logic [15:0] rev16(logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    function automatic logic [15:0] model_crc(int len);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < len; i++)
            if (i >= int'(m_off) && i < int'(m_off) + 128 && m_mask[i - int'(m_off)])
                c = crc_byte(c, fr[i]);
        return rev16(c);
    endfunction

    function automatic logic model_match(int len);
        int  last = 0;
        logic any = |m_mask;
        logic bc = (len >= 6);
        for (int i = 0; i < 128; i++) if (m_mask[i]) last = i;
        for (int i = 0; i < 6 && i < len; i++) if (fr[i] != 8'hFF) bc = 1'b0;
        if (!m_en) return 1'b0;
        if (!any && !m_bc && !m_mc) return 1'b0;
        if (any && (len - 1) < int'(m_off) + last) return 1'b0;
        if (m_bc && !bc) return 1'b0;
        if (m_mc && !fr[0][0]) return 1'b0;
        return model_crc(len) == m_exp;
    endfunction

    task automatic wr(int a, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // program through the register map of R2
    task automatic program_filter(logic en, logic bc, logic mc, logic [7:0] off,
                                  logic [15:0] exp, logic [127:0] msk);
        m_en = en; m_bc = bc; m_mc = mc; m_off = off; m_exp = exp; m_mask = msk;
        wr(1, exp);
        for (int g = 0; g < 8; g++) wr(9 - g, msk[g*16 +: 16]);
        wr(0, {en, 5'b0, mc, bc, off});
    endtask

    task automatic send(string req, int len, bit gaps, logic exp);
        logic early = 1'b0;
        logic m1, m2;
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                if (match_o) early = 1'b1;
                rx_valid = 1'b0; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 8'h5A;
            end
            @(negedge clk);
            if (match_o) early = 1'b1;
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_data = fr[i];
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h00;
        m1 = match_o;
        @(negedge clk);
        m2 = match_o;
        check({req, " pulse"}, 32'(m1), 32'(exp));
        check({req, " R5 quiet"}, 32'({early, m2}), 32'd0);
    endtask

    task automatic fill_frame(int len, logic [7:0] seed);
        for (int i = 0; i < len; i++) fr[i] = 8'(i * 37) ^ seed;
    endtask

    task automatic set_dest(logic [7:0] b);
        for (int i = 0; i < 6; i++) fr[i] = b;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] arp_exp;
        logic [15:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset match", 32'(match_o), 32'd0);

        // R1: registers zero after reset -> a multicast frame does not match
        m_en = 0; m_bc = 0; m_mc = 0; m_off = 0; m_exp = 0; m_mask = '0;
        fill_frame(64, 8'h11); set_dest(8'h01);
        send("R1 unprogrammed", 64, 0, 1'b0);

        // R4: bench reference CRC against a known value
        c = 16'hFFFF;
        for (int i = 0; i < 9; i++) c = crc_byte(c, 8'(8'h31 + i));
        check("R4 reference vector", 32'(rev16(c)), 32'h0000ECD2);

        // R4/R3: "123456789" at offset 0, mask 0x01FF
        fill_frame(40, 8'h00);
        for (int i = 0; i < 9; i++) fr[i] = 8'(8'h31 + i);
        program_filter(1, 0, 0, 8'd0, 16'hECD2, 128'h1FF);
        send("R4 known crc", 40, 0, 1'b1);

        // broadcast ARP filter
        fill_frame(64, 8'h22);
        fr[12] = 8'h08; fr[13] = 8'h06;
        m_off = 8'd12; m_mask = 128'h3;
        arp_exp = model_crc(64);
        program_filter(1, 1, 0, 8'd12, arp_exp, 128'h3);
        set_dest(8'hFF);
        send("R7 bcast ARP", 64, 0, model_match(64));
        check("R7 model expects match", 32'(model_match(64)), 32'd1);
        fr[3] = 8'h12;
        send("R7 unicast ARP", 64, 0, 1'b0);
        set_dest(8'hFF); fr[13] = 8'h00;
        send("R3 bcast IPv4", 64, 0, 1'b0);
        fr[13] = 8'h06;
        send("R9 truncated", 13, 0, 1'b0);
        send("R9 exact length", 14, 0, 1'b1);
        send("R11 gapped frame", 64, 1, 1'b1);

        // R6: disabled
        program_filter(0, 1, 0, 8'd12, arp_exp, 128'h3);
        send("R6 disabled", 64, 0, 1'b0);

        // R8: multicast, empty mask
        program_filter(1, 0, 1, 8'd0, 16'hFFFF, 128'h0);
        fill_frame(60, 8'h33); fr[0] = 8'h01;
        send("R8 mcast frame", 60, 0, 1'b1);
        fr[0] = 8'h02;
        send("R8 unicast frame", 60, 0, 1'b0);

        // R10: empty mask, no qualifier
        program_filter(1, 0, 0, 8'd0, 16'hFFFF, 128'h0);
        fr[0] = 8'h01;
        send("R10 empty filter", 60, 0, 1'b0);

        // R2/R3 sweep: every mask word, several offsets, right and wrong CRC
        for (int oi = 0; oi < 3; oi++) begin
            for (int g = 0; g < 8; g++) begin
                for (int bad = 0; bad < 2; bad++) begin
                    logic [127:0] msk;
                    logic [7:0]   off;
                    logic [15:0]  e;
                    off = (oi == 0) ? 8'd0 : (oi == 1) ? 8'd3 : 8'd20;
                    msk = '0;
                    msk[g*16 + (g*5) % 16] = 1'b1;
                    msk[g*16 + (g*5 + 7) % 16] = 1'b1;
                    fill_frame(160, 8'(g * 11 + oi));
                    m_off = off; m_mask = msk;
                    e = model_crc(160) ^ 16'(bad);
                    program_filter(1, 0, 0, off, e, msk);
                    send("R2 R3 sweep", 160, (g % 2) == 1, model_match(160));
                    check("R2 sweep model", 32'(model_match(160)), 32'(bad == 0));
                end
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule